// File: doc/BRIEF.md
# Tournament Best-Pair Selection Sequencer

This block picks, from a bank of nominally identical device pairs, the pair with the smallest mismatch. It uses nothing but a one-bit comparator result. It runs a knockout tournament. Two candidates sit in positions A and B, and each comparison takes two phases. In the first phase both pairs are connected normally, and the synchronized comparator result is latched at the end of the phase. In the second phase the pair in position B is connected reversed. The new result is XORed with the latched one. A change of state means B carries the larger offset and loses; no change means A loses. The losing position's select code is replaced by the next candidate code, while the winner's code stays put. After the last candidate has been tried, the winner becomes the survivor.

The top holds one independent tournament engine per bank; by default there are two banks, one for n-type pairs and one for p-type pairs. Each engine drives:
- the A and B select codes for the external decoders,
- the reverse strobe for position B,
- the comparator enable,
- a toggle for dynamic element matching inside the comparator.

A synchronous start pulse begins a selection, or restarts one that is under way. The downstream reference enable stays low until every bank has chosen its survivor. Phase lengths and the swap-toggle divider are counted in system clock cycles.

Top module: `pair_survivor_top`

## Requirements
- R1: One cycle after a start pulse, every bank has select code 0 on A and 1 on B, comparator enable high and done low. While the comparator is enabled, the A and B codes always differ.
- R2: Each comparison holds reverse-B low for PH1_CYC cycles, then high for PH2_CYC cycles. The comparator is sampled only in the last cycle of each phase.
- R3: If the phase-two result differs from the latched phase-one result, B loses; otherwise A loses. Only the loser's select takes the next candidate code (2, 3, ... in order), and the winner's select is unchanged.
- R4: Done rises exactly (N_PAIRS-1)*(PH1_CYC+PH2_CYC) cycles after the start edge. The survivor code is then the pair with the smallest absolute offset.
- R5: While comparing, the swap toggle inverts every SWAP_DIV cycles. When not comparing, the swap toggle and the comparator enable are both low.
- R6: The reference enable is low from a start pulse until all banks are done. It goes high one cycle after the last bank finishes.
- R7: A start pulse during a selection restarts the tournament from codes 0 and 1, and the new run gives the correct survivor.
- R8: After done, the survivor code, the select codes and done stay fixed until the next start, whatever the comparator does.
- R9: An active-low asynchronous reset leaves done, the enables, the swap toggle, the selects and the survivor all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous pulse that starts or restarts selection |
| cmp_i | input | N_BANKS | Asynchronous comparator result per bank |
| sel_a_o | output | N_BANKS x CODE_W | Position A candidate code per bank |
| sel_b_o | output | N_BANKS x CODE_W | Position B candidate code per bank |
| rev_b_o | output | N_BANKS | Reverse connection of position B (phase two) |
| swap_o | output | N_BANKS | Matching-swap toggle for the comparator |
| cmp_en_o | output | N_BANKS | Comparator enable |
| done_o | output | N_BANKS | Survivor chosen |
| survivor_o | output | N_BANKS x CODE_W | Final survivor code |
| ref_en_o | output | 1 | Downstream reference and cascode enable |

## Verification
The bench models each comparator from a per-pair signed offset table, so the two-phase XOR gives the true ordering of offset magnitudes. Tables put the best pair first, last and in the middle of the bank. This separates a correct loser choice from a swapped one, and shows whether the first comparison replaces A or B. A restarted run with a fresh table checks that no state survives a restart. A toggling comparator after done checks that the result is frozen.

// File: rtl/pair_sel_pkg.sv
package pair_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2,
    ST_DONE = 2'd3
  } tour_state_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swap_gen.sv
module swap_gen #(
  parameter int SWAP_DIV = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic swap_o
);
  localparam int DW = (SWAP_DIV > 1) ? $clog2(SWAP_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SWAP_DIV - 1);

  logic [DW-1:0] div_q;
  logic          swap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      swap_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      div_q  <= '0;
      swap_q <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q  <= '0;
      swap_q <= ~swap_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assign swap_o = swap_q;
endmodule

// File: rtl/tourney_engine.sv
module tourney_engine
  import pair_sel_pkg::*;
#(
  parameter int N_PAIRS = 16,
  parameter int PH1_CYC = 75000,
  parameter int PH2_CYC = 75000,
  parameter int CODE_W  = $clog2(N_PAIRS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_s_i,
  output logic [CODE_W-1:0] sel_a_o,
  output logic [CODE_W-1:0] sel_b_o,
  output logic              rev_b_o,
  output logic              cmp_en_o,
  output logic              active_next_o,
  output logic              done_o,
  output logic [CODE_W-1:0] survivor_o
);
  localparam int CNT_W  = CODE_W + 1;
  localparam int PH_MAX = (PH1_CYC > PH2_CYC) ? PH1_CYC : PH2_CYC;
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam logic [PH_W-1:0]  P1_LAST  = PH_W'(PH1_CYC - 1);
  localparam logic [PH_W-1:0]  P2_LAST  = PH_W'(PH2_CYC - 1);
  localparam logic [CNT_W-1:0] CAND_END = CNT_W'(N_PAIRS);

  tour_state_e       state_q;
  logic [PH_W-1:0]   ph_cnt_q;
  logic [CNT_W-1:0]  cand_q;
  logic [CODE_W-1:0] sel_a_q, sel_b_q, surv_q;
  logic              lat_q;
  logic              b_loses, ph2_end, last_round;

  assign b_loses    = cmp_s_i ^ lat_q;  // state reversal: B has the larger offset
  assign ph2_end    = (state_q == ST_PH2) && (ph_cnt_q == P2_LAST);
  assign last_round = (cand_q == CAND_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ph_cnt_q <= '0;
      cand_q   <= '0;
      sel_a_q  <= '0;
      sel_b_q  <= '0;
      surv_q   <= '0;
      lat_q    <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_PH1;
      ph_cnt_q <= '0;
      cand_q   <= CNT_W'(2);
      sel_a_q  <= CODE_W'(0);
      sel_b_q  <= CODE_W'(1);
      surv_q   <= '0;
      lat_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PH1: begin
          if (ph_cnt_q == P1_LAST) begin
            lat_q    <= cmp_s_i;
            ph_cnt_q <= '0;
            state_q  <= ST_PH2;
          end else begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
          end
        end
        ST_PH2: begin
          if (ph2_end) begin
            ph_cnt_q <= '0;
            if (last_round) begin
              state_q <= ST_DONE;
              surv_q  <= b_loses ? sel_a_q : sel_b_q;
            end else begin
              if (b_loses) sel_b_q <= cand_q[CODE_W-1:0];
              else         sel_a_q <= cand_q[CODE_W-1:0];
              cand_q  <= cand_q + 1'b1;
              state_q <= ST_PH1;
            end
          end else begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sel_a_o       = sel_a_q;
  assign sel_b_o       = sel_b_q;
  assign rev_b_o       = (state_q == ST_PH2);
  assign cmp_en_o      = (state_q == ST_PH1) || (state_q == ST_PH2);
  assign done_o        = (state_q == ST_DONE);
  assign survivor_o    = surv_q;
  assign active_next_o = start_i || (state_q == ST_PH1) ||
                         ((state_q == ST_PH2) && !(ph2_end && last_round));

  // R1: candidates in the two positions never coincide
  assert_sel_distinct_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_o |-> (sel_a_o != sel_b_o));

  // R2: phase one never reverses B
  assert_ph1_normal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PH1) |-> !rev_b_o);

  // R3: a round boundary replaces exactly one position
  assert_one_loser_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_PH1) && ($past(state_q) == ST_PH2) && !$past(start_i))
      |-> ($stable(sel_a_o) ^ $stable(sel_b_o)));

  // R8: result frozen until the next start
  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(survivor_o) && $stable(sel_a_o)));
endmodule

// File: rtl/pair_survivor_top.sv
module pair_survivor_top #(
  parameter int N_BANKS  = 2,
  parameter int N_PAIRS  = 16,
  parameter int PH1_CYC  = 75000,
  parameter int PH2_CYC  = 75000,
  parameter int SWAP_DIV = 500,
  parameter int CODE_W   = $clog2(N_PAIRS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [N_BANKS-1:0]             cmp_i,
  output logic [N_BANKS-1:0][CODE_W-1:0] sel_a_o,
  output logic [N_BANKS-1:0][CODE_W-1:0] sel_b_o,
  output logic [N_BANKS-1:0]             rev_b_o,
  output logic [N_BANKS-1:0]             swap_o,
  output logic [N_BANKS-1:0]             cmp_en_o,
  output logic [N_BANKS-1:0]             done_o,
  output logic [N_BANKS-1:0][CODE_W-1:0] survivor_o,
  output logic                           ref_en_o
);
  logic [N_BANKS-1:0] cmp_s, active_next;
  logic               ref_en_q;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    cmp_sync #(.STAGES(2)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (cmp_i[b]),
      .q_o   (cmp_s[b])
    );

    tourney_engine #(
      .N_PAIRS(N_PAIRS),
      .PH1_CYC(PH1_CYC),
      .PH2_CYC(PH2_CYC),
      .CODE_W (CODE_W)
    ) u_engine (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start_i),
      .cmp_s_i      (cmp_s[b]),
      .sel_a_o      (sel_a_o[b]),
      .sel_b_o      (sel_b_o[b]),
      .rev_b_o      (rev_b_o[b]),
      .cmp_en_o     (cmp_en_o[b]),
      .active_next_o(active_next[b]),
      .done_o       (done_o[b]),
      .survivor_o   (survivor_o[b])
    );

    swap_gen #(.SWAP_DIV(SWAP_DIV)) u_swap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (start_i),
      .en_i  (active_next[b]),
      .swap_o(swap_o[b])
    );

    // R5: no swap clocking outside comparisons
    assert_swap_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmp_en_o[b] |-> !swap_o[b]);
  end

  // Reference held off until every bank has its survivor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ref_en_q <= 1'b0;
    else if (start_i) ref_en_q <= 1'b0;
    else              ref_en_q <= &done_o;
  end

  assign ref_en_o = ref_en_q;

  assert_ref_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o |-> (&done_o));
endmodule

// File: tb/pair_survivor_top_bench.sv
module pair_survivor_top_bench;
  localparam int NB = 2;
  localparam int NP = 16;
  localparam int CW = 4;
  localparam int P1 = 8;
  localparam int P2 = 8;
  localparam int SD = 2;
  localparam int RUN_CYC = (NP - 1) * (P1 + P2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NB-1:0] cmp;
  logic [NB-1:0][CW-1:0] sel_a, sel_b, surv;
  logic [NB-1:0] rev_b, swap, cmp_en, done;
  logic ref_en;
  logic noise_en = 1'b0;
  logic noise_bit = 1'b0;
  int off [NB][NP];
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pair_survivor_top #(
    .N_BANKS(NB), .N_PAIRS(NP), .PH1_CYC(P1), .PH2_CYC(P2), .SWAP_DIV(SD)
  ) u_pair_survivor_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_i(cmp),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .rev_b_o(rev_b), .swap_o(swap),
    .cmp_en_o(cmp_en), .done_o(done), .survivor_o(surv), .ref_en_o(ref_en)
  );

  function automatic logic cmp_model(input int a, input int b, input logic rv);
    return rv ? ((a - b) > 0) : ((a + b) > 0);
  endfunction

  always @(negedge clk) noise_bit <= ~noise_bit;

  always_comb begin
    cmp[0] = noise_en ? noise_bit  : cmp_model(off[0][sel_a[0]], off[0][sel_b[0]], rev_b[0]);
    cmp[1] = noise_en ? ~noise_bit : cmp_model(off[1][sel_a[1]], off[1][sel_b[1]], rev_b[1]);
  end

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int best_of(input int b);
    int idx = 0;
    for (int i = 1; i < NP; i++)
      if (iabs(off[b][i]) < iabs(off[b][idx])) idx = i;
    return idx;
  endfunction

  task automatic fill(input int b, input int best, input int k);
    for (int i = 0; i < NP; i++)
      off[b][i] = (((i + k) % 3) == 0 ? -1 : 1) * (10 + ((i * 7 + k) % 16) * 3);
    off[b][best] = (k % 2) ? -1 : 1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Full tournament from a start pulse, checking every milestone
  task automatic run_full;
    int toggles = 0;
    logic [NB-1:0] prev_swap;
    int ea [NB];
    int eb [NB];
    for (int b = 0; b < NB; b++) begin
      ea[b] = (iabs(off[b][1]) > iabs(off[b][0])) ? 0 : 2;
      eb[b] = (iabs(off[b][1]) > iabs(off[b][0])) ? 2 : 1;
    end
    pulse_start();
    for (int b = 0; b < NB; b++) begin
      chk("R1 sel_a after start", sel_a[b], 0);
      chk("R1 sel_b after start", sel_b[b], 1);
      chk("R1 cmp_en after start", cmp_en[b], 1);
    end
    chk("R1 done after start", done, 0);
    chk("R6 ref_en after start", ref_en, 0);
    prev_swap = swap;
    for (int i = 1; i <= P1 + P2; i++) begin
      @(negedge clk);
      if (swap[0] != prev_swap[0]) toggles++;
      prev_swap = swap;
      if (i == P1 - 1) chk("R2 rev_b low in phase one", rev_b, 0);
      if (i == P1)     chk("R2 rev_b high in phase two", rev_b, 3);
    end
    chk("R5 swap toggles per comparison", toggles, (P1 + P2) / SD);
    chk("R2 rev_b low after round", rev_b, 0);
    for (int b = 0; b < NB; b++) begin
      chk("R3 sel_a after first round", sel_a[b], ea[b]);
      chk("R3 sel_b after first round", sel_b[b], eb[b]);
    end
    for (int i = P1 + P2 + 1; i <= RUN_CYC; i++) begin
      @(negedge clk);
      if (i == RUN_CYC - 1) chk("R4 done not early", done, 0);
    end
    chk("R4 done on time", done, 3);
    chk("R6 ref_en one cycle late", ref_en, 0);
    @(negedge clk);
    chk("R6 ref_en after all done", ref_en, 1);
    chk("R5 cmp_en off after done", cmp_en, 0);
    chk("R5 swap off after done", swap, 0);
    for (int b = 0; b < NB; b++) chk("R4 survivor", surv[b], best_of(b));
  endtask

  task automatic t_reset;
    chk("R9 done at reset", done, 0);
    chk("R9 cmp_en at reset", cmp_en, 0);
    chk("R9 swap at reset", swap, 0);
    chk("R9 ref_en at reset", ref_en, 0);
    chk("R9 survivor at reset", surv, 0);
    chk("R9 selects at reset", {sel_a, sel_b}, 0);
  endtask

  task automatic t_hold;
    logic [NB-1:0][CW-1:0] s0, a0, b0;
    s0 = surv; a0 = sel_a; b0 = sel_b;
    noise_en = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 survivor held", surv, s0);
    chk("R8 sel_a held", sel_a, a0);
    chk("R8 sel_b held", sel_b, b0);
    chk("R8 done held", done, 3);
    noise_en = 1'b0;
  endtask

  task automatic t_restart;
    fill(0, 4, 5); fill(1, 11, 2);
    pulse_start();
    repeat (50) @(negedge clk);
    fill(0, 9, 3); fill(1, 3, 6);
    run_full();
    chk("R7 survivor bank0 after restart", surv[0], 9);
    chk("R7 survivor bank1 after restart", surv[1], 3);
  endtask

  task automatic t_async_reset;
    pulse_start();
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 cmp_en on reset mid-run", cmp_en, 0);
    chk("R9 done on reset mid-run", done, 0);
    chk("R9 selects on reset mid-run", {sel_a, sel_b}, 0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    fill(0, 0, 1); fill(1, 1, 4);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_full();                       // best first / best second
    t_hold();
    fill(0, 15, 2); fill(1, 7, 5);
    run_full();                       // best last / best middle
    t_restart();
    t_async_reset();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule